// File: doc/BRIEF.md
# Storage PHY Power Sequencer

This block is a hardware state machine that brings an analog storage-interface PHY up or down without software timing loops. A power-off request drops the PHY power enable and the DLL enable and reports completion one cycle later. A power-on request does the same first. It then applies the drive-strength and output-delay settings, waits a settle interval, and raises the power enable. Next it waits for the PHY's calibration flag and loads a DLL frequency band chosen from the supplied clock rate. Finally it enables the DLL and waits for lock.

Each wait is measured in microseconds from a tick divided down from the system clock. The two waits on PHY status each have a bound. Exceeding a bound ends the sequence with a dedicated error flag. A rate of zero means the card clock is not yet running. In that case the DLL is still enabled, but the lock wait is skipped. Alongside the band, the block flags rates that lie too far from their band's nominal frequency for accurate tuning.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset, or once a power-off request is accepted, `pwr_en_o` and `dll_en_o` are 0. A power-off raises `done_o` on the second clock edge after the request is sampled, with no error flag set.
- R2: On an accepted power-on request, `pwr_en_o` and `dll_en_o` drop at once. `pwr_en_o` rises no sooner than SETTLE_US microseconds later.
- R3: If the synchronised calibration flag is not seen within CAL_TO_US microseconds of `pwr_en_o` rising, `err_cal_o` is set, `dll_en_o` stays 0 and the sequence stops.
- R4: `freq_band_o` is 1 for a rate of 1 to 74 999 999 Hz and 2 for 75 000 000 to 124 999 999 Hz. It is 3 for 125 000 000 to 174 999 999 Hz. It is 0 for a rate of zero or any rate from 175 000 000 Hz up.
- R5: The band nominals are 50, 100, 150 and 200 MHz for codes 1, 2, 3 and 0. `rate_warn_o` is 1 when the rate exceeds 200 MHz. It is also 1 when the rate exceeds 50 MHz and lies more than 15 MHz from its band nominal.
- R6: `freq_band_o` is loaded after calibration completes and is unchanged on the cycle `dll_en_o` rises. `dll_en_o` is only ever 1 while `pwr_en_o` is 1.
- R7: With a rate of zero, `dll_en_o` is set and `done_o` rises on the same edge, with no wait for DLL ready.
- R8: With a nonzero rate, if the synchronised DLL-ready flag is not seen within LOCK_TO_US microseconds of `dll_en_o` rising, `err_dll_o` is set.
- R9: The drive code follows the impedance in ohms: 50 maps to 0, 33 to 1, 66 to 2, 100 to 3 and 40 to 4. Any other value maps to 0.
- R10: From the acceptance of a power-on, before `pwr_en_o` rises, `otap_en_o` is 1, `otap_sel_o` is 4 and `drv_code_o` holds the R9 code.
- R11: A request arriving while a sequence runs has no effect. `done_o`, `err_cal_o` and `err_dll_o` are mutually exclusive. They hold their value until the next request is accepted, which clears them.
- R12: The calibration and DLL-ready status inputs pass through a two-flop synchroniser before the state machine acts on them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| on_req_i | input | 1 | Power-on request strobe (wins over off) |
| off_req_i | input | 1 | Power-off request strobe |
| rate_hz_i | input | 32 | Card clock rate in Hz, sampled at power-on |
| imp_ohm_i | input | IMP_W | Drive impedance in ohms, sampled at power-on |
| cal_done_i | input | 1 | PHY calibration finished (asynchronous) |
| dll_rdy_i | input | 1 | PHY DLL locked (asynchronous) |
| pwr_en_o | output | 1 | PHY analog power enable (power-down-bar) |
| dll_en_o | output | 1 | PHY DLL enable |
| freq_band_o | output | 2 | DLL frequency band code |
| drv_code_o | output | 3 | Output drive-strength code |
| otap_en_o | output | 1 | Output tap delay enable |
| otap_sel_o | output | 4 | Output tap delay select |
| done_o | output | 1 | Sequence completed |
| err_cal_o | output | 1 | Calibration timed out |
| err_dll_o | output | 1 | DLL lock timed out |
| rate_warn_o | output | 1 | Rate outside the tuning tolerance |

## Verification
The assertions check the ordering rules on every cycle. The DLL enable never runs ahead of the power enable, the band is stable when the DLL turns on, and the tap settings are in place whenever power is up. The completion flags stay exclusive, and each error appears only with the control state its phase implies. Some properties can only be shown by the bench's scenarios. These are the settle and timeout windows measured in clock cycles, the exact band and warning values at range edges such as 74 999 999, 75 000 000, 65 000 000 and 65 000 001 Hz, and the zero-rate shortcut. The same holds for the impedance fallback and the rejection of requests that arrive mid-sequence.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_OFF, S_SETTLE, S_CAL, S_DLL, S_LOCK
  } seq_state_e;

  localparam logic [31:0] LIM_B1   = 32'd75_000_000;
  localparam logic [31:0] LIM_B2   = 32'd125_000_000;
  localparam logic [31:0] LIM_B3   = 32'd175_000_000;
  localparam logic [31:0] NOM_B1   = 32'd50_000_000;
  localparam logic [31:0] NOM_B2   = 32'd100_000_000;
  localparam logic [31:0] NOM_B3   = 32'd150_000_000;
  localparam logic [31:0] NOM_B0   = 32'd200_000_000;
  localparam logic [31:0] TOL_HZ   = 32'd15_000_000;
  localparam logic [3:0]  OTAP_DLY = 4'd4;

  function automatic logic [2:0] ohm_to_drv(input logic [15:0] ohm);
    case (ohm)
      16'd33:  return 3'd1;
      16'd66:  return 3'd2;
      16'd100: return 3'd3;
      16'd40:  return 3'd4;
      default: return 3'd0;  // 50 ohm and any unsupported value
    endcase
  endfunction

endpackage

// File: rtl/sync2.sv
module sync2 #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/us_timer.sv
module us_timer #(
  parameter int CLK_MHZ = 200,
  parameter int MAX_US  = 50000,
  localparam int PW     = $clog2(CLK_MHZ + 1),
  localparam int UW     = $clog2(MAX_US + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [UW-1:0] us_o
);
  logic [PW-1:0] pre_q;
  logic          tick;

  assign tick = (pre_q == PW'(CLK_MHZ - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      us_o  <= '0;
    end else if (clr_i) begin
      pre_q <= '0;
      us_o  <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick && us_o != UW'(MAX_US)) us_o <= us_o + 1'b1;
    end
  end
endmodule

// File: rtl/rate_band.sv
module rate_band
  import phy_seq_pkg::*;
(
  input  logic [31:0] rate_i,
  output logic [1:0]  band_o,
  output logic        warn_o
);
  logic [31:0] nom, diff;

  always_comb begin
    if (rate_i == '0)         begin band_o = 2'd0; nom = NOM_B0; end
    else if (rate_i < LIM_B1) begin band_o = 2'd1; nom = NOM_B1; end
    else if (rate_i < LIM_B2) begin band_o = 2'd2; nom = NOM_B2; end
    else if (rate_i < LIM_B3) begin band_o = 2'd3; nom = NOM_B3; end
    else                      begin band_o = 2'd0; nom = NOM_B0; end
    diff   = (rate_i > nom) ? rate_i - nom : nom - rate_i;
    warn_o = (rate_i > NOM_B0) || (rate_i > NOM_B1 && diff > TOL_HZ);
  end
endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
  import phy_seq_pkg::*;
#(
  parameter int CLK_MHZ    = 200,
  parameter int SETTLE_US  = 3,
  parameter int CAL_TO_US  = 50,
  parameter int LOCK_TO_US = 50000,
  parameter int IMP_W      = 8,
  localparam int MAX_A     = (SETTLE_US > CAL_TO_US) ? SETTLE_US : CAL_TO_US,
  localparam int MAX_US    = (MAX_A > LOCK_TO_US) ? MAX_A : LOCK_TO_US,
  localparam int UW        = $clog2(MAX_US + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             on_req_i,
  input  logic             off_req_i,
  input  logic [31:0]      rate_hz_i,
  input  logic [IMP_W-1:0] imp_ohm_i,
  input  logic             cal_done_i,
  input  logic             dll_rdy_i,
  output logic             pwr_en_o,
  output logic             dll_en_o,
  output logic [1:0]       freq_band_o,
  output logic [2:0]       drv_code_o,
  output logic             otap_en_o,
  output logic [3:0]       otap_sel_o,
  output logic             done_o,
  output logic             err_cal_o,
  output logic             err_dll_o,
  output logic             rate_warn_o
);
  seq_state_e    state_q, state_d;
  logic [UW-1:0] us_cnt;
  logic [1:0]    stat_s;
  logic          cal_s, lock_s;
  logic [1:0]    band_c, band_q;
  logic          warn_c, zero_q;

  sync2 #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i({dll_rdy_i, cal_done_i}), .q_o(stat_s)
  );
  assign cal_s  = stat_s[0];
  assign lock_s = stat_s[1];

  us_timer #(.CLK_MHZ(CLK_MHZ), .MAX_US(MAX_US)) u_tmr (
    .clk_i, .rst_ni, .clr_i(state_d != state_q), .us_o(us_cnt)
  );

  rate_band u_band (.rate_i(rate_hz_i), .band_o(band_c), .warn_o(warn_c));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (on_req_i) state_d = S_SETTLE;
                else if (off_req_i) state_d = S_OFF;
      S_OFF:    state_d = S_IDLE;
      S_SETTLE: if (us_cnt == UW'(SETTLE_US)) state_d = S_CAL;
      S_CAL:    if (cal_s) state_d = S_DLL;
                else if (us_cnt == UW'(CAL_TO_US)) state_d = S_IDLE;
      S_DLL:    state_d = zero_q ? S_IDLE : S_LOCK;
      S_LOCK:   if (lock_s || us_cnt == UW'(LOCK_TO_US)) state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      pwr_en_o    <= 1'b0;
      dll_en_o    <= 1'b0;
      freq_band_o <= '0;
      drv_code_o  <= '0;
      otap_en_o   <= 1'b0;
      otap_sel_o  <= '0;
      done_o      <= 1'b0;
      err_cal_o   <= 1'b0;
      err_dll_o   <= 1'b0;
      rate_warn_o <= 1'b0;
      band_q      <= '0;
      zero_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        S_IDLE: if (on_req_i || off_req_i) begin
          pwr_en_o  <= 1'b0;
          dll_en_o  <= 1'b0;
          done_o    <= 1'b0;
          err_cal_o <= 1'b0;
          err_dll_o <= 1'b0;
          if (on_req_i) begin
            drv_code_o  <= ohm_to_drv(16'(imp_ohm_i));
            otap_en_o   <= 1'b1;
            otap_sel_o  <= OTAP_DLY;
            band_q      <= band_c;
            rate_warn_o <= warn_c;
            zero_q      <= (rate_hz_i == '0);
          end else begin
            rate_warn_o <= 1'b0;
          end
        end
        S_OFF:    done_o <= 1'b1;
        S_SETTLE: if (state_d == S_CAL) pwr_en_o <= 1'b1;
        S_CAL: begin
          if (cal_s) freq_band_o <= band_q;
          else if (state_d == S_IDLE) err_cal_o <= 1'b1;
        end
        S_DLL: begin
          dll_en_o <= 1'b1;
          if (zero_q) done_o <= 1'b1;  // no input clock: lock cannot be awaited
        end
        S_LOCK: begin
          if (lock_s) done_o <= 1'b1;
          else if (state_d == S_IDLE) err_dll_o <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  p_dll_needs_pwr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dll_en_o |-> pwr_en_o);
  p_band_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dll_en_o) |-> $stable(freq_band_o));
  p_end_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_cal_o, err_dll_o}));
  p_cal_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_cal_o) |-> pwr_en_o && !dll_en_o);
  p_dll_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_dll_o) |-> dll_en_o && pwr_en_o);
  p_otap_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_en_o |-> otap_en_o && otap_sel_o == 4'd4);
  p_busy_ignore_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_LOCK && off_req_i && !lock_s && us_cnt != UW'(LOCK_TO_US)) |=> dll_en_o);
endmodule

// File: tb/phy_pwr_seq_test.sv
module phy_pwr_seq_test;
  localparam int CLK_MHZ = 4, SET_US = 3, CAL_US = 10, LCK_US = 20;

  logic        clk = 0, rst_n = 0;
  logic        on_req = 0, off_req = 0, cal_done = 0, dll_rdy = 0;
  logic [31:0] rate = 0;
  logic [7:0]  ohm = 0;
  logic        pwr_en, dll_en, otap_en, done, err_cal, err_dll, warn;
  logic [1:0]  band;
  logic [2:0]  drv;
  logic [3:0]  otap_sel;

  always #2.5 clk = ~clk;

  phy_pwr_seq #(.CLK_MHZ(CLK_MHZ), .SETTLE_US(SET_US), .CAL_TO_US(CAL_US),
                .LOCK_TO_US(LCK_US), .IMP_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .on_req_i(on_req), .off_req_i(off_req),
    .rate_hz_i(rate), .imp_ohm_i(ohm), .cal_done_i(cal_done), .dll_rdy_i(dll_rdy),
    .pwr_en_o(pwr_en), .dll_en_o(dll_en), .freq_band_o(band), .drv_code_o(drv),
    .otap_en_o(otap_en), .otap_sel_o(otap_sel), .done_o(done),
    .err_cal_o(err_cal), .err_dll_o(err_dll), .rate_warn_o(warn)
  );

  typedef struct {
    int kind;        // 0 done, 1 cal error, 2 dll error
    bit is_on;
    bit dll;
    logic [1:0] band;
    bit warn;
    logic [2:0] drv;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_band(input logic [31:0] r);
    if (r == 0) return 2'd0;
    if (r <= 32'd74_999_999) return 2'd1;
    if (r <= 32'd124_999_999) return 2'd2;
    if (r <= 32'd174_999_999) return 2'd3;
    return 2'd0;
  endfunction

  function automatic bit exp_warn(input logic [31:0] r);
    longint nom, d;
    case (exp_band(r))
      2'd1: nom = 50_000_000;
      2'd2: nom = 100_000_000;
      2'd3: nom = 150_000_000;
      default: nom = 200_000_000;
    endcase
    d = (longint'(r) > nom) ? longint'(r) - nom : nom - longint'(r);
    return (longint'(r) > 200_000_000) || (longint'(r) > 50_000_000 && d > 15_000_000);
  endfunction

  function automatic logic [2:0] exp_drv(input int o);
    case (o)
      50: return 3'd0;
      33: return 3'd1;
      66: return 3'd2;
      100: return 3'd3;
      40: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // Monitor: pops an expected item whenever an end flag rises.
  logic fin_prev = 0;
  always @(negedge clk) begin
    logic fin;
    fin = done | err_cal | err_dll;
    if (rst_n && fin && !fin_prev) begin
      if (exp_q.size() == 0) chk(0, "R11", "unexpected completion", 1, 0);
      else begin
        exp_t e;
        int k;
        e = exp_q.pop_front();
        k = err_cal ? 1 : err_dll ? 2 : 0;
        chk(k == e.kind, e.kind == 1 ? "R3" : e.kind == 2 ? "R8" : "R1", "outcome", k, e.kind);
        chk(dll_en == e.dll, "R6", "dll_en at end", dll_en, e.dll);
        chk(warn == e.warn, "R5", "rate_warn", warn, e.warn);
        if (e.is_on) begin
          chk(drv == e.drv, "R9", "drive code", drv, e.drv);
          if (e.kind != 1) chk(band == e.band, "R4", "freq band", band, e.band);
        end
      end
    end
    fin_prev = fin;
  end

  task automatic run_on(input logic [31:0] r, input int o, input int cal_dly,
                        input int dll_dly, input bit poke);
    exp_t e;
    int n, m, t_dll;
    bit seen;
    e.is_on = 1;
    e.kind  = (cal_dly < 0) ? 1 : (r != 0 && dll_dly < 0) ? 2 : 0;
    e.dll   = (e.kind != 1);
    e.band  = exp_band(r);
    e.warn  = exp_warn(r);
    e.drv   = exp_drv(o);
    exp_q.push_back(e);
    cal_done = 0; dll_rdy = 0; rate = r; ohm = 8'(o);
    @(negedge clk) on_req = 1;
    @(negedge clk) on_req = 0;
    n = 1;
    chk(!pwr_en && !dll_en, "R2", "controls low after accept", {pwr_en, dll_en}, 0);
    chk(!done && !err_cal && !err_dll, "R11", "end flags cleared", {done, err_cal, err_dll}, 0);
    chk(otap_en && otap_sel == 4, "R10", "tap delay before power", otap_sel, 4);
    chk(drv == exp_drv(o), "R10", "drive code before power", drv, exp_drv(o));
    if (poke) off_req = 1;
    while (!pwr_en && n < 200) begin
      @(negedge clk) n++;
      off_req = 0;
    end
    chk(n >= SET_US * CLK_MHZ && n <= SET_US * CLK_MHZ + 2, "R2", "settle cycles", n, SET_US * CLK_MHZ + 1);
    m = 0; seen = 0; t_dll = 0;
    while (m < 3000) begin
      if (cal_dly >= 0 && m == cal_dly) cal_done = 1;
      if (dll_en && !seen) begin
        seen = 1; t_dll = m;
        chk(band == exp_band(r), "R6", "band loaded before dll enable", band, exp_band(r));
        if (poke) off_req = 1;
      end else off_req = 0;
      if (seen && dll_dly >= 0 && m == t_dll + dll_dly) dll_rdy = 1;
      if (done || err_cal || err_dll) break;
      @(negedge clk) m++;
    end
    off_req = 0;
    if (e.kind == 1)
      chk(m >= CAL_US * CLK_MHZ && m <= CAL_US * CLK_MHZ + 2, "R3", "cal timeout cycles", m, CAL_US * CLK_MHZ + 1);
    if (e.kind == 2)
      chk(m - t_dll >= LCK_US * CLK_MHZ && m - t_dll <= LCK_US * CLK_MHZ + 2, "R8", "lock timeout cycles",
          m - t_dll, LCK_US * CLK_MHZ + 1);
    if (r == 0) chk(seen && m == t_dll && done, "R7", "zero rate done with dll enable", m - t_dll, 0);
    if (e.kind == 0 && r != 0)
      chk(m - t_dll >= dll_dly + 3, "R12", "lock seen through synchroniser", m - t_dll, dll_dly + 3);
    repeat (20) @(negedge clk);
    chk((done | err_cal | err_dll) == 1'b1, "R11", "end flag held", {done, err_cal, err_dll}, 1);
  endtask

  task automatic run_off();
    exp_t e;
    e.is_on = 0; e.kind = 0; e.dll = 0; e.band = 0; e.warn = 0; e.drv = 0;
    exp_q.push_back(e);
    @(negedge clk) off_req = 1;
    @(negedge clk) off_req = 0;
    chk(!pwr_en && !dll_en && !done, "R1", "off lowers controls", {pwr_en, dll_en, done}, 0);
    @(negedge clk);
    chk(done && !err_cal && !err_dll, "R1", "off reports done", done, 1);
    repeat (5) @(negedge clk);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    chk(!pwr_en && !dll_en && !done && !err_cal && !err_dll, "R1", "reset state",
        {pwr_en, dll_en, done, err_cal, err_dll}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_on(32'd50_000_000, 50, 5, 10, 0);
    run_on(32'd100_000_000, 33, 0, 0, 0);
    run_on(32'd66_000_000, 66, 8, 4, 0);
    run_on(32'd150_000_000, 100, 3, 6, 1);   // mid-run requests ignored (R11)
    run_on(32'd200_000_000, 40, 2, 2, 0);
    run_on(32'd210_000_000, 77, 2, 2, 0);
    run_on(32'd74_999_999, 50, 1, 1, 0);
    run_on(32'd75_000_000, 50, 1, 1, 0);
    run_on(32'd174_999_999, 50, 1, 1, 0);
    run_on(32'd175_000_000, 50, 1, 1, 0);
    run_on(32'd1, 50, 1, 1, 0);
    run_on(32'd65_000_000, 50, 1, 1, 0);
    run_on(32'd65_000_001, 50, 1, 1, 0);
    run_off();
    run_on(32'd0, 50, 4, -1, 0);
    run_on(32'd100_000_000, 66, -1, -1, 0);
    run_on(32'd120_000_000, 40, 3, -1, 0);
    run_off();
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R11", "all results seen", exp_q.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog: actual hung expected finished");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule